// File: doc/BRIEF.md
# Absolute Gray Rotary Knob Decoder

This block reads a sixteen-detent absolute rotary knob whose four contacts carry a Gray code. Each contact is pulled up, so an open contact reads as 1 and the idle level of every synchronizer flop is 1. The raw contacts pass through a two-flop synchronizer and a stability filter. A code is accepted only after it has held unchanged for `STABLE_CYCLES` clock cycles. The accepted code is converted from Gray to a binary position from 0 to 15.

A small tracker state machine compares each accepted position with the one it holds. It has two states. `ST_EMPTY` is entered at reset and means no position has been learned yet. Transition `LOAD` goes from `ST_EMPTY` to `ST_TRACK` on the first accepted code: it captures the position and issues no step. `ST_TRACK` loops on itself through three transitions. `STEP` fires when the new position is the held one plus or minus 1 modulo 16, and produces a one-cycle step strobe with a direction bit. `JUMP` fires on any other change, and raises a one-cycle illegal-jump flag and takes the new position. `HOLD` fires when the position is equal or nothing was accepted, and does nothing.

Turning clockwise walks the codes 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8, which decode to positions 0 through 15 in that order. Because the arithmetic is modulo 16, a clockwise step from code 8 back to code 0 is reported as an ordinary step.

Top module: `gray_knob_decoder`

## Requirements
- R1: A contact pattern is accepted only after it has held unchanged for STABLE_CYCLES clock cycles after the synchronizer. Patterns that change back before then (contact bounce) change no output.
- R2: Accepted Gray code g converts to binary b with b[3]=g[3] and b[i]=b[i+1] XOR g[i]. The clockwise code sequence 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8 therefore maps to positions 0..15.
- R3: The first code accepted after reset sets `pos` and raises neither `step_valid` nor `jump_err`.
- R4: When a new position equals the held position +1 modulo 16, `step_valid` is high for one cycle with `step_cw`=1 (clockwise), and `pos` takes the new value.
- R5: When a new position equals the held position −1 modulo 16, `step_valid` is high for one cycle with `step_cw`=0 (counter-clockwise), and `pos` takes the new value.
- R6: The wrap between position 15 (code 8) and position 0 (code 0) counts as a single step in either direction.
- R7: Any other change of position raises `jump_err` for one cycle, takes the new position and raises no step.
- R8: During and right after reset, `pos`=0 and `step_valid`, `step_cw`, `jump_err` are 0. A code that is accepted again with the same position produces no strobe.
- R9: `step_valid` and `jump_err` are never high together, and neither stays high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| knob_raw | input | 4 | Raw Gray contacts from the knob, pulled up (open = 1) |
| pos | output | 4 | Binary knob position 0..15 |
| step_valid | output | 1 | One-cycle strobe for a single-detent move |
| step_cw | output | 1 | Direction of the last step, 1 = clockwise |
| jump_err | output | 1 | One-cycle flag for a move that is not a single detent |

## Verification
The hardest situation to reach from the ports is contact bounce. Bounce must never leak out as a step, yet the same code held a little longer must still be accepted. The stimulus toggles one contact repeatedly with pulses shorter than the stability window, then returns to the original code. It checks that neither the position nor any strobe moved. The other hard-to-reach cases are the first load after reset while the contacts idle high, and the two wrap directions between code 8 and code 0. The vector table and a full clockwise sweep reach both of these on purpose.

// File: rtl/gray_knob_pkg.sv
package gray_knob_pkg;
    localparam int KNOB_W = 4;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;
endpackage

// File: rtl/gk_sync.sv
module gk_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_in[i];
                sync_q <= meta_q;
            end
        end
        assign d_out[i] = sync_q;
    end
endmodule

// File: rtl/gk_debounce.sv
module gk_debounce #(
    parameter int W             = 4,
    parameter int STABLE_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_in,
    output logic         acc_valid,
    output logic [W-1:0] acc_code
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [W-1:0]     cand_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q    <= '1;
            cnt_q     <= '0;
            acc_valid <= 1'b0;
            acc_code  <= '1;
        end else begin
            acc_valid <= 1'b0;
            if (code_in != cand_q) begin
                cand_q <= code_in;
                cnt_q  <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    acc_valid <= 1'b1;
                    acc_code  <= cand_q;
                end
            end
        end
    end

    // R1: an accepted code matches what the synchronizer presented
    assert_accept_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ($past(code_in) == acc_code));
endmodule

// File: rtl/gk_gray2bin.sv
module gk_gray2bin #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    always_comb begin
        bin = gray;
        for (int i = W - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end

    // R2: re-encoding the binary result must give back the Gray input
    always_comb begin
        if (!$isunknown(gray)) begin
            assert_roundtrip_R2: assert ((bin ^ (bin >> 1)) == gray);
        end
    end
endmodule

// File: rtl/gk_tracker.sv
module gk_tracker
    import gray_knob_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_valid,
    input  logic [W-1:0] acc_pos,
    output logic [W-1:0] pos,
    output logic         step_valid,
    output logic         step_cw,
    output logic         jump_err
);
    localparam logic [W-1:0] UP_ONE   = W'(1);
    localparam logic [W-1:0] DOWN_ONE = '1;

    trk_state_t state_q, state_d;
    logic [W-1:0] delta;

    assign delta = acc_pos - pos;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (acc_valid) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            step_valid <= 1'b0;
            step_cw    <= 1'b0;
            jump_err   <= 1'b0;
        end else begin
            step_valid <= 1'b0;
            jump_err   <= 1'b0;
            unique case (state_q)
                ST_EMPTY: begin
                    if (acc_valid) pos <= acc_pos;
                end
                ST_TRACK: begin
                    if (acc_valid && delta != '0) begin
                        pos <= acc_pos;
                        if (delta == UP_ONE) begin
                            step_valid <= 1'b1;
                            step_cw    <= 1'b1;
                        end else if (delta == DOWN_ONE) begin
                            step_valid <= 1'b1;
                            step_cw    <= 1'b0;
                        end else begin
                            jump_err <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: nothing is reported while no position is known yet
    assert_first_load_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (!step_valid && !jump_err));
    // R4
    assert_cw_plus_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_cw) |-> (pos == $past(pos) + UP_ONE));
    // R5
    assert_ccw_minus_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_cw) |-> (pos == $past(pos) - UP_ONE));
    // R7
    assert_jump_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_err |-> (pos != $past(pos) && pos != $past(pos) + UP_ONE
                      && pos != $past(pos) - UP_ONE));
    // R9
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_valid && jump_err));
    assert_step_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);
    assert_jump_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        jump_err |=> !jump_err);
endmodule

// File: rtl/gray_knob_decoder.sv
module gray_knob_decoder
    import gray_knob_pkg::*;
#(
    parameter int STABLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KNOB_W-1:0] knob_raw,
    output logic [KNOB_W-1:0] pos,
    output logic              step_valid,
    output logic              step_cw,
    output logic              jump_err
);
    logic [KNOB_W-1:0] sync_code;
    logic [KNOB_W-1:0] acc_code;
    logic [KNOB_W-1:0] acc_pos;
    logic              acc_valid;

    gk_sync #(.W(KNOB_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(knob_raw), .d_out(sync_code)
    );

    gk_debounce #(.W(KNOB_W), .STABLE_CYCLES(STABLE_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .code_in(sync_code),
        .acc_valid(acc_valid), .acc_code(acc_code)
    );

    gk_gray2bin #(.W(KNOB_W)) u_g2b (
        .gray(acc_code), .bin(acc_pos)
    );

    gk_tracker #(.W(KNOB_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pos(acc_pos),
        .pos(pos), .step_valid(step_valid), .step_cw(step_cw), .jump_err(jump_err)
    );
endmodule

// File: tb/gray_knob_decoder_bench.sv
module gray_knob_decoder_bench;
    localparam int STABLE = 8;
    localparam int SETTLE = STABLE + 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] knob_raw = 4'hF;
    logic [3:0] pos;
    logic       step_valid, step_cw, jump_err;

    int total = 0;
    int bad = 0;
    int n_cw = 0, n_ccw = 0, n_jump = 0;

    always #2 clk = ~clk;

    gray_knob_decoder #(.STABLE_CYCLES(STABLE)) u_gray_knob_decoder (
        .clk(clk), .rst_n(rst_n), .knob_raw(knob_raw),
        .pos(pos), .step_valid(step_valid), .step_cw(step_cw), .jump_err(jump_err)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (step_valid && step_cw)  n_cw++;
            if (step_valid && !step_cw) n_ccw++;
            if (jump_err)               n_jump++;
        end
    end

    // clockwise code order, index = expected position
    localparam logic [3:0] CW_SEQ [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                                           4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

    // {code, expected pos, kind}: kind 0 none, 1 cw, 2 ccw, 3 jump
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {4'h0, 4'd0,  2'd3},   // R7
        {4'h1, 4'd1,  2'd1},   // R4
        {4'h3, 4'd2,  2'd1},
        {4'h2, 4'd3,  2'd1},
        {4'h3, 4'd2,  2'd2},   // R5
        {4'hC, 4'd8,  2'd3},
        {4'h8, 4'd15, 2'd3},
        {4'h0, 4'd0,  2'd1},   // R6 wrap cw
        {4'h8, 4'd15, 2'd2},   // R6 wrap ccw
        {4'h9, 4'd14, 2'd2},
        {4'hB, 4'd13, 2'd2},
        {4'hB, 4'd13, 2'd0},   // R8 same code
        {4'h6, 4'd4,  2'd3},
        {4'h7, 4'd5,  2'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    function automatic int kind_now(input int c0, input int c1, input int j0);
        int dc = n_cw - c0;
        int dw = n_ccw - c1;
        int dj = n_jump - j0;
        if (dc == 0 && dw == 0 && dj == 0) return 0;
        if (dc == 1 && dw == 0 && dj == 0) return 1;
        if (dc == 0 && dw == 1 && dj == 0) return 2;
        if (dc == 0 && dw == 0 && dj == 1) return 3;
        return 9;
    endfunction

    initial begin
        #(4ns * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, c1, j0, k;
        // R8: reset state
        repeat (4) @(negedge clk);
        check(pos == 4'd0 && !step_valid && !step_cw && !jump_err, "R8 reset outputs",
              {pos, step_valid, step_cw, jump_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pos == 4'd0, "R8 pos after reset release", pos, 0);

        // R3: contacts idle high, first load of code F -> position 10 without strobe
        c0 = n_cw; c1 = n_ccw; j0 = n_jump;
        settle();
        check(pos == 4'd10, "R3 first load pos", pos, 10);
        check(kind_now(c0, c1, j0) == 0, "R3 first load no strobe", kind_now(c0, c1, j0), 0);

        // table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            c0 = n_cw; c1 = n_ccw; j0 = n_jump;
            knob_raw = VEC[v][9:6];
            settle();
            k = kind_now(c0, c1, j0);
            check(pos == VEC[v][5:2], "R2 table pos", pos, int'(VEC[v][5:2]));
            check(k == int'(VEC[v][1:0]), "R4 R5 R6 R7 table kind", k, int'(VEC[v][1:0]));
        end

        // R2 R4: full clockwise sweep from position 5, wrapping through 15 to 0
        for (int s = 6; s < 6 + 16; s++) begin
            c0 = n_cw; c1 = n_ccw; j0 = n_jump;
            knob_raw = CW_SEQ[s % 16];
            settle();
            k = kind_now(c0, c1, j0);
            check(pos == 4'(s % 16), "R2 sweep pos", pos, s % 16);
            check(k == 1 && step_cw, "R4 sweep cw step", k, 1);
        end

        // R1: bounce on one contact shorter than the window
        c0 = n_cw; c1 = n_ccw; j0 = n_jump;
        for (int b = 0; b < 6; b++) begin
            knob_raw = CW_SEQ[6];
            repeat (STABLE - 3) @(negedge clk);
            knob_raw = CW_SEQ[5];
            repeat (STABLE - 3) @(negedge clk);
        end
        check(pos == 4'd5, "R1 bounce pos held", pos, 5);
        settle();
        k = kind_now(c0, c1, j0);
        check(pos == 4'd5, "R1 bounce settled pos", pos, 5);
        check(k == 0, "R1 bounce no strobe", k, 0);

        // R5: counter-clockwise from 5 down across a few detents
        for (int s = 4; s >= 2; s--) begin
            c0 = n_cw; c1 = n_ccw; j0 = n_jump;
            knob_raw = CW_SEQ[s];
            settle();
            k = kind_now(c0, c1, j0);
            check(pos == 4'(s) && k == 2 && !step_cw, "R5 ccw run", {pos, 4'(k)}, {s, 4'd2});
        end

        // R3 again: reset mid-use with knob on code D (pos 9)
        rst_n = 1'b0;
        knob_raw = 4'hD;
        repeat (3) @(negedge clk);
        check(pos == 4'd0 && !step_cw, "R8 reset clears", pos, 0);
        rst_n = 1'b1;
        c0 = n_cw; c1 = n_ccw; j0 = n_jump;
        settle();
        k = kind_now(c0, c1, j0);
        check(pos == 4'd9 && k == 0, "R3 reload without strobe", {pos, 4'(k)}, {4'd9, 4'd0});

        // R9 observed via counters: one strobe per single-step move
        c0 = n_cw; c1 = n_ccw; j0 = n_jump;
        knob_raw = 4'hF;
        settle();
        check(n_cw - c0 == 1 && n_jump == j0, "R9 single pulse", n_cw - c0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule